// File: doc/BRIEF.md
# Nonvolatile RAM Control Mode Decoder

This block sits behind the four active-low control pins of a battery-free nonvolatile static memory: chip enable, write enable, output enable and nonvolatile enable. It brings the asynchronous pins into the local clock domain through two-flop synchronizers. It then classifies the synchronized combination as one of eight device modes and drives the data-bus output enable. This enable is high only for an ordinary array read.

Bulk copies between the shadow store and the working array are expensive and must never start on noise. Store and recall requests therefore go to the transfer sequencer only after the pattern has been sampled unchanged for a parameterised number of consecutive cycles. This count is derived from the clock period and the glitch threshold. Each request is a single-cycle pulse, issued once per qualified assertion. The request re-arms only after a non-transfer pattern has itself stayed stable for the same qualification window. An all-low pattern is meaningless, and it raises a sticky flag that a separate synchronous input clears.

Top module: `nv_mode_decoder`

## Requirements
- R1: While and after reset (asynchronous, active-low `rstN`), with the pins idle, `mode` reads 0 (deselected), `busDriveEn` is low, both requests are low and `illegalFlag` is low.
- R2: With chip enable high, `mode` is 0 and `busDriveEn` is low whatever the other three pins are.
- R3: Chip enable and output enable low with write and nonvolatile enable high gives `mode` 1 (read). `busDriveEn` is high in this mode and in no other.
- R4: Chip enable and write enable low with output and nonvolatile enable high gives `mode` 2 (write). Chip enable low with nonvolatile enable high in any other write/output combination gives `mode` 3 (output disabled).
- R5: Chip, output and nonvolatile enable low with write enable high gives `mode` 4 (recall). Nonvolatile enable low with output and write enable both high gives `mode` 6 (no operation).
- R6: Chip, write and nonvolatile enable low with output enable high gives `mode` 5 (store). All four low gives `mode` 7 (illegal), so a low output enable prevents any store request.
- R7: A pin change is reflected on `mode` after the second rising clock edge that samples it, and not after the first.
- R8: A store or recall pattern that is sampled on fewer than QUAL_CYCLES consecutive edges produces no request.
- R9: A store or recall pattern held for at least QUAL_CYCLES samples produces exactly one request pulse, one cycle wide, on the matching output, however long it is held.
- R10: A new request is allowed only after a non-transfer pattern has been held for QUAL_CYCLES samples. Going directly from store to recall issues nothing, and neither does a transfer pattern held across reset.
- R11: `illegalFlag` sets one cycle after `mode` shows 7 and stays set until `illegalClr` is high in a cycle with no illegal pattern. An illegal pattern wins over a simultaneous clear.
- R12: `storeReq` and `recallReq` are never high in the same cycle. Each pulse follows a cycle in which the synchronized mode matched it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable pin, active low, asynchronous |
| weN | input | 1 | Write enable pin, active low, asynchronous |
| oeN | input | 1 | Output enable pin, active low, asynchronous |
| neN | input | 1 | Nonvolatile enable pin, active low, asynchronous |
| illegalClr | input | 1 | Synchronous clear of the illegal-combination flag |
| mode | output | 3 | Decoded mode of the synchronized pins (0..7) |
| busDriveEn | output | 1 | Data-bus output enable, high only in read mode |
| storeReq | output | 1 | One-cycle store request to the transfer sequencer |
| recallReq | output | 1 | One-cycle recall request to the transfer sequencer |
| illegalFlag | output | 1 | Sticky flag for an all-low control pattern |

## Verification
The bench builds the block with a 10 ns clock period and a 40 ns glitch threshold, which gives a qualification window of five samples. With that window, a pattern of four samples is a real rejection case. It is distinct from both the five-sample acceptance edge and a long hold of twenty cycles. These values also leave room to test release windows that are too short to re-arm the request, with every scenario finishing in a few dozen cycles.

// File: rtl/nv_decoder_pkg.sv
package nv_decoder_pkg;

  typedef enum logic [2:0] {
    MODE_DESEL   = 3'd0,
    MODE_READ    = 3'd1,
    MODE_WRITE   = 3'd2,
    MODE_OUTOFF  = 3'd3,
    MODE_RECALL  = 3'd4,
    MODE_STORE   = 3'd5,
    MODE_NOOP    = 3'd6,
    MODE_ILLEGAL = 3'd7
  } nvMode_e;

  typedef struct packed {
    logic ceN;
    logic weN;
    logic oeN;
    logic neN;
  } ctlPins_t;

  typedef struct packed {
    logic fireStore;
    logic fireRecall;
    logic markIllegal;
  } nvStrobe_t;

  localparam ctlPins_t PINS_IDLE = '{ceN: 1'b1, weN: 1'b1, oeN: 1'b1, neN: 1'b1};

  function automatic nvMode_e decodePins(input ctlPins_t p);
    nvMode_e m;
    if (p.ceN) begin
      m = MODE_DESEL;
    end else if (p.neN) begin
      if (!p.oeN && p.weN)      m = MODE_READ;
      else if (!p.weN && p.oeN) m = MODE_WRITE;
      else                      m = MODE_OUTOFF;
    end else begin
      case ({p.oeN, p.weN})
        2'b01:   m = MODE_RECALL;
        2'b10:   m = MODE_STORE;
        2'b11:   m = MODE_NOOP;
        default: m = MODE_ILLEGAL;
      endcase
    end
    return m;
  endfunction

endpackage

// File: rtl/nv_pin_sync.sv
module nv_pin_sync #(
  parameter int WIDTH = 4,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RESET_VAL = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= {STAGES{RESET_VAL[b]}};
      else       chain <= {chain[STAGES-2:0], asyncIn[b]};
    end
    assign syncOut[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/nv_decoder_datapath.sv
module nv_decoder_datapath
  import nv_decoder_pkg::*;
#(
  parameter int QUAL_CYCLES = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  ctlPins_t  syncPins,
  input  nvStrobe_t strobes,
  input  logic      illegalClr,
  output ctlPins_t  heldPins,
  output logic      heldOk,
  output logic      storeReq,
  output logic      recallReq,
  output logic      illegalFlag
);

  localparam int CW = $clog2(QUAL_CYCLES + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(QUAL_CYCLES);

  logic [CW-1:0] runLen;

  // run length of the current synchronized pattern, saturating at the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldPins <= PINS_IDLE;
      runLen   <= '0;
    end else if (syncPins != heldPins) begin
      heldPins <= syncPins;
      runLen   <= CW'(1);
    end else if (runLen < CNT_MAX) begin
      runLen <= runLen + CW'(1);
    end
  end

  assign heldOk = (runLen == CNT_MAX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeReq    <= 1'b0;
      recallReq   <= 1'b0;
      illegalFlag <= 1'b0;
    end else begin
      storeReq  <= strobes.fireStore;
      recallReq <= strobes.fireRecall;
      if (strobes.markIllegal) illegalFlag <= 1'b1;
      else if (illegalClr)     illegalFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/nv_decoder_ctrl.sv
module nv_decoder_ctrl
  import nv_decoder_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ctlPins_t  syncPins,
  input  ctlPins_t  heldPins,
  input  logic      heldOk,
  output nvMode_e   mode,
  output logic      busDriveEn,
  output nvStrobe_t strobes
);

  nvMode_e heldMode;
  logic    armed;
  logic    heldIsXfer;

  always_comb begin
    mode       = decodePins(syncPins);
    heldMode   = decodePins(heldPins);
    busDriveEn = (mode == MODE_READ);
    heldIsXfer = (heldMode == MODE_STORE) || (heldMode == MODE_RECALL);
    strobes.fireStore   = heldOk && armed && (heldMode == MODE_STORE);
    strobes.fireRecall  = heldOk && armed && (heldMode == MODE_RECALL);
    strobes.markIllegal = (mode == MODE_ILLEGAL);
  end

  // disarmed out of reset; re-armed only by a qualified non-transfer pattern
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                        armed <= 1'b0;
    else if (strobes.fireStore || strobes.fireRecall) armed <= 1'b0;
    else if (heldOk && !heldIsXfer)                   armed <= 1'b1;
  end

endmodule

// File: rtl/nv_mode_decoder.sv
module nv_mode_decoder
  import nv_decoder_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int GLITCH_PS     = 20000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       weN,
  input  logic       oeN,
  input  logic       neN,
  input  logic       illegalClr,
  output logic [2:0] mode,
  output logic       busDriveEn,
  output logic       storeReq,
  output logic       recallReq,
  output logic       illegalFlag
);

  localparam int QUAL_CYCLES = (GLITCH_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS + 1;

  ctlPins_t  rawPins, syncPins, heldPins;
  logic      heldOk;
  nvStrobe_t strobes;
  nvMode_e   modeEnum;

  assign rawPins = '{ceN: ceN, weN: weN, oeN: oeN, neN: neN};
  assign mode    = modeEnum;

  nv_pin_sync #(
    .WIDTH(4), .STAGES(SYNC_STAGES), .RESET_VAL(4'b1111)
  ) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(rawPins), .syncOut(syncPins)
  );

  nv_decoder_datapath #(.QUAL_CYCLES(QUAL_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .syncPins(syncPins), .strobes(strobes),
    .illegalClr(illegalClr), .heldPins(heldPins), .heldOk(heldOk),
    .storeReq(storeReq), .recallReq(recallReq), .illegalFlag(illegalFlag)
  );

  nv_decoder_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .syncPins(syncPins), .heldPins(heldPins),
    .heldOk(heldOk), .mode(modeEnum), .busDriveEn(busDriveEn), .strobes(strobes)
  );

endmodule

// File: rtl/nv_mode_decoder_chk.sv
module nv_mode_decoder_chk (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] mode,
  input logic       busDriveEn,
  input logic       storeReq,
  input logic       recallReq,
  input logic       illegalFlag,
  input logic       illegalClr
);

  // R12
  excl_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(storeReq && recallReq));

  // R9
  store_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq);

  // R9
  recall_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq);

  // R12
  store_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |-> $past(mode, 2) == 3'd5);

  // R12
  recall_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |-> $past(mode, 2) == 3'd4);

  // R11
  illegal_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    mode == 3'd7 |=> illegalFlag);

  // R11
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalFlag && !illegalClr |=> illegalFlag);

  // R3
  bus_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busDriveEn |-> mode == 3'd1);

endmodule

bind nv_mode_decoder nv_mode_decoder_chk u_chk (
  .clk(clk), .rstN(rstN), .mode(mode), .busDriveEn(busDriveEn),
  .storeReq(storeReq), .recallReq(recallReq), .illegalFlag(illegalFlag),
  .illegalClr(illegalClr)
);

// File: tb/nv_mode_decoder_tb.sv
module nv_mode_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int QUAL = 5;  // 40 ns threshold at 10 ns period

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ceN = 1'b1, weN = 1'b1, oeN = 1'b1, neN = 1'b1;
  logic illegalClr = 1'b0;
  logic [2:0] mode;
  logic busDriveEn, storeReq, recallReq, illegalFlag;

  int checks = 0;
  int fails = 0;
  int storeCnt = 0, recallCnt = 0, storeRun = 0, recallRun = 0, maxRun = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  nv_mode_decoder #(.CLK_PERIOD_PS(10000), .GLITCH_PS(40000)) u_dut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .weN(weN), .oeN(oeN), .neN(neN),
    .illegalClr(illegalClr), .mode(mode), .busDriveEn(busDriveEn),
    .storeReq(storeReq), .recallReq(recallReq), .illegalFlag(illegalFlag)
  );

  // pulse monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (storeReq && !storeRun[0]) storeCnt++;
    if (recallReq && !recallRun[0]) recallCnt++;
    storeRun  = storeReq  ? storeRun + 1 : 0;
    recallRun = recallReq ? recallRun + 1 : 0;
    if (storeRun > maxRun) maxRun = storeRun;
    if (recallRun > maxRun) maxRun = recallRun;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pins(input logic c, input logic w, input logic o, input logic n);
    ceN = c; weN = w; oeN = o; neN = n;
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clearCounts();
    storeCnt = 0; recallCnt = 0; maxRun = 0;
  endtask

  task automatic expectMode(input logic c, input logic w, input logic o, input logic n,
                            input int expMode, input bit expBus, input string tag);
    pins(c, w, o, n);
    step(3);
    chk(mode == expMode, tag, mode, expMode);
    chk(busDriveEn == expBus, tag, busDriveEn, expBus);
  endtask

  task automatic testReset();
    // R1
    chk(mode == 0, "R1 mode", mode, 0);
    chk(!busDriveEn && !storeReq && !recallReq, "R1 outputs",
        {busDriveEn, storeReq, recallReq}, 0);
    chk(!illegalFlag, "R1 flag", illegalFlag, 0);
  endtask

  task automatic testDecode();
    for (int k = 0; k < 8; k++)  // R2: ce high masks everything
      expectMode(1'b1, k[2], k[1], k[0], 0, 1'b0, "R2 deselect");
    expectMode(1'b0, 1'b1, 1'b0, 1'b1, 1, 1'b1, "R3 read");
    expectMode(1'b0, 1'b0, 1'b1, 1'b1, 2, 1'b0, "R4 write");
    expectMode(1'b0, 1'b1, 1'b1, 1'b1, 3, 1'b0, "R4 outoff idle");
    expectMode(1'b0, 1'b0, 1'b0, 1'b1, 3, 1'b0, "R4 outoff we+oe");
    expectMode(1'b0, 1'b1, 1'b0, 1'b0, 4, 1'b0, "R5 recall");
    expectMode(1'b0, 1'b1, 1'b1, 1'b0, 6, 1'b0, "R5 noop");
    expectMode(1'b0, 1'b0, 1'b1, 1'b0, 5, 1'b0, "R6 store");
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 3);
  endtask

  task automatic testLatency();
    // R7
    pins(1'b0, 1'b1, 1'b0, 1'b1);
    step(1);
    chk(mode == 0, "R7 one edge", mode, 0);
    step(1);
    chk(mode == 1, "R7 two edges", mode, 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 3);
  endtask

  task automatic testGlitch();
    // R8
    clearCounts();
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    step(QUAL - 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 6);
    chk(storeCnt == 0, "R8 short store", storeCnt, 0);
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    step(QUAL - 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 6);
    chk(recallCnt == 0, "R8 short recall", recallCnt, 0);
  endtask

  task automatic testQualify();
    // R9 exact window
    clearCounts();
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    step(QUAL);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 6);
    chk(storeCnt == 1, "R9 store at window", storeCnt, 1);
    chk(recallCnt == 0, "R12 no cross recall", recallCnt, 0);
    // R9 long hold
    clearCounts();
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    step(20);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 6);
    chk(recallCnt == 1, "R9 recall long hold", recallCnt, 1);
    chk(maxRun == 1, "R9 pulse width", maxRun, 1);
    chk(storeCnt == 0, "R12 no cross store", storeCnt, 0);
  endtask

  task automatic testRearm();
    // R10 store straight into recall
    clearCounts();
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    step(15);
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    step(15);
    chk(storeCnt == 1 && recallCnt == 0, "R10 no direct rearm", recallCnt, 0);
    // R10 release shorter than window does not rearm
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL - 1);
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    step(15);
    chk(recallCnt == 0, "R10 short release", recallCnt, 0);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 3);
    pins(1'b0, 1'b1, 1'b0, 1'b0);
    step(15);
    chk(recallCnt == 1, "R10 rearm after release", recallCnt, 1);
    // R10 pattern held across reset
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    rstN = 1'b0;
    step(3);
    rstN = 1'b1;
    clearCounts();
    step(20);
    chk(storeCnt == 0, "R10 held across reset", storeCnt, 0);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 3);
    pins(1'b0, 1'b0, 1'b1, 1'b0);
    step(15);
    chk(storeCnt == 1, "R10 store after reset release", storeCnt, 1);
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(QUAL + 3);
  endtask

  task automatic testIllegal();
    // R11 / R6: all low is illegal, no store
    clearCounts();
    pins(1'b0, 1'b0, 1'b0, 1'b0);
    step(1);
    chk(!illegalFlag, "R11 not yet set", illegalFlag, 0);
    step(1);
    chk(mode == 7, "R6 illegal mode", mode, 7);
    step(1);
    chk(illegalFlag, "R11 set", illegalFlag, 1);
    step(10);
    chk(storeCnt == 0, "R6 oe veto store", storeCnt, 0);
    illegalClr = 1'b1;  // set wins
    step(2);
    chk(illegalFlag, "R11 set wins", illegalFlag, 1);
    illegalClr = 1'b0;
    pins(1'b1, 1'b1, 1'b1, 1'b1);
    step(4);
    chk(illegalFlag, "R11 sticky", illegalFlag, 1);
    illegalClr = 1'b1;
    step(1);
    illegalClr = 1'b0;
    chk(!illegalFlag, "R11 cleared", illegalFlag, 0);
  endtask

  initial begin
    step(3);
    testReset();
    rstN = 1'b1;
    step(2);
    testReset();
    step(QUAL + 2);
    testDecode();
    testLatency();
    testGlitch();
    testQualify();
    testRearm();
    testIllegal();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule